// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog Mode

This block is a countdown timer that sits on a simple peripheral bus with write and read strobes, a word address and byte enables. Software loads a 32-bit period word holding a clock divider in its upper half and a tick limit in its lower half. It then turns the timer on through a control word. Both halves count from one, and a zero in either half stands for 65536. The timer expires after divider × limit clock edges. On expiry it either stops (single shot) or reloads and runs again (repeating). Each expiry sets a status flag that can drive an interrupt line.

The same counter chain can act as a watchdog. In that case an expiry does not set the flag. Instead it sends a one-cycle pulse on a reset-request output, and the counter keeps reloading. Software keeps the pulse away by writing the key byte 0xA5 into the top byte of the control word, which restarts the count. Every output of the block is registered.

Top module: `tmr_wdog`

## Requirements
- R1: After a synchronous reset, the control word, period word and status word all read zero, and `irq_o` and `wdog_rst_o` are low.
- R2: Word address 1 holds the period word. Bits 31:16 are the divider P and bits 15:0 are the limit T. With the timer enabled, expiry falls on clock edge P×T counted from the edge that enables it.
- R3: A divider or limit value of zero counts as 65536. With P=0 and T=1, expiry falls on edge 65536.
- R4: Word address 0 holds the control word, with enable in bit 12. When bit 10 is clear, an expiry sets status bit 0, clears bit 12, and the timer fires only once.
- R5: When control bit 10 is set, the timer reloads on expiry and fires again every P×T edges, for as long as bit 12 stays set.
- R6: `irq_o` equals status bit 0 AND control bit 8. Status (word address 2) bit 0 is cleared by writing a one to it, and writing a zero leaves it unchanged.
- R7: Clearing control bit 12 part way through a period stops counting, and no expiry follows.
- R8: Writing the period word while the timer is enabled restarts the count with the new values from that write edge.
- R9: When control bit 15 is set, each expiry drives `wdog_rst_o` high for exactly one cycle and leaves status bit 0 clear. The counter reloads whatever bit 10 holds, and bit 12 stays set.
- R10: When control bit 15 is set, a write to address 0 whose byte enable 3 is set and whose data bits 31:24 equal 0xA5 restarts the count. Any other value in that byte has no effect.
- R11: A key write with only byte enable 3 set leaves the control bits unchanged. With bit 15 clear, a key write does not delay the expiry.
- R12: A read returns data on `bus_rdata` in the cycle after the read strobe. Bits with no storage read zero, and address 3 reads zero. Writes to the period word obey the byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word select: 0 control, 1 period, 2 status |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Expiry interrupt, registered |
| wdog_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
The bench measures expiry to the exact clock edge for several divider and limit pairs, including the zero-means-65536 case. An off-by-one in either stage would make the interrupt rise one edge early or one prescaled period late. It re-writes the period word in mid-count and sends key writes both in timer mode and with the wrong key byte. A design that restarts on any top-byte write, or that ignores the restart, would move the reset pulse to a different edge. It also checks that a watchdog expiry never raises the flag, that the pulse lasts one cycle, and that single-shot mode clears the enable bit. A design that got these wrong would interrupt during watchdog duty or keep firing after a single shot.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned PRE_LSB = 16;

  typedef enum logic [1:0] {
    ADR_MODE  = 2'd0,
    ADR_COUNT = 2'd1,
    ADR_STAT  = 2'd2,
    ADR_RSVD  = 2'd3
  } tmr_addr_e;

  localparam int unsigned MB_IE   = 8;
  localparam int unsigned MB_CONT = 10;
  localparam int unsigned MB_EN   = 12;
  localparam int unsigned MB_WD   = 15;

  localparam logic [7:0] SERVICE_KEY = 8'hA5;

  typedef struct packed {
    logic wd;
    logic en;
    logic cont;
    logic ie;
  } tmr_mode_t;
endpackage

// File: rtl/tmr_div.sv
module tmr_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic         last;

  // a limit of zero wraps the compare, giving 2**W steps
  assign last = (cnt_q + W'(1)) == lim;
  assign tick = run & step & ~clr & last;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt_q <= '0;
    else if (step)          cnt_q <= last ? '0 : cnt_q + W'(1);
  end

  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       addr,
  input  logic [3:0]       be,
  input  logic [BUS_W-1:0] wdata,
  input  logic             expire,
  output tmr_mode_t        mode,
  output logic [PRE_W-1:0] pre_lim,
  output logic [CNT_W-1:0] cnt_lim,
  output logic             restart,
  output logic [BUS_W-1:0] rdata,
  output logic             irq,
  output logic             wdog_rst
);
  localparam int NBYTES = BUS_W / 8;
  localparam logic [BUS_W-1:0] PERIOD_MASK =
    ((((BUS_W)'(1)) << PRE_W) - (BUS_W)'(1)) << PRE_LSB |
    ((((BUS_W)'(1)) << CNT_W) - (BUS_W)'(1));

  function automatic logic [BUS_W-1:0] merge_bytes(
    input logic [BUS_W-1:0] old_w, input logic [BUS_W-1:0] new_w,
    input logic [NBYTES-1:0] en_b);
    logic [BUS_W-1:0] r;
    r = old_w;
    for (int i = 0; i < NBYTES; i++)
      if (en_b[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] mode_to_word(input tmr_mode_t m);
    logic [BUS_W-1:0] w;
    w = '0;
    w[MB_WD]   = m.wd;
    w[MB_EN]   = m.en;
    w[MB_CONT] = m.cont;
    w[MB_IE]   = m.ie;
    return w;
  endfunction

  tmr_mode_t        mode_q, mode_d;
  logic [BUS_W-1:0] period_q, period_d;
  logic             flag_q, flag_d;
  logic [BUS_W-1:0] rdata_q;
  logic             irq_q, wd_q;
  logic             wr_mode, wr_count, wr_stat, service;
  logic [BUS_W-1:0] mode_wr_word;

  assign wr_mode  = wr && (addr == ADR_MODE);
  assign wr_count = wr && (addr == ADR_COUNT);
  assign wr_stat  = wr && (addr == ADR_STAT);
  assign service  = wr_mode && be[NBYTES-1] && mode_q.wd &&
                    (wdata[BUS_W-1 -: 8] == SERVICE_KEY);
  assign restart  = wr_count || service;

  always_comb begin
    mode_d   = mode_q;
    period_d = period_q;
    flag_d   = flag_q;
    if (expire && !mode_q.wd && !mode_q.cont) mode_d.en = 1'b0;
    mode_wr_word = merge_bytes(mode_to_word(mode_d), wdata, be);
    if (wr_mode) begin
      mode_d.wd   = mode_wr_word[MB_WD];
      mode_d.en   = mode_wr_word[MB_EN];
      mode_d.cont = mode_wr_word[MB_CONT];
      mode_d.ie   = mode_wr_word[MB_IE];
    end
    if (wr_count) period_d = merge_bytes(period_q, wdata, be) & PERIOD_MASK;
    if (wr_stat && be[0] && wdata[0]) flag_d = 1'b0;
    if (expire && !mode_q.wd) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      period_q <= '0;
      flag_q   <= 1'b0;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
      wd_q     <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      period_q <= period_d;
      flag_q   <= flag_d;
      irq_q    <= flag_d & mode_d.ie;
      wd_q     <= expire & mode_q.wd;
      if (rd) begin
        case (addr)
          ADR_MODE:  rdata_q <= mode_to_word(mode_q);
          ADR_COUNT: rdata_q <= period_q;
          ADR_STAT:  rdata_q <= {{(BUS_W-1){1'b0}}, flag_q};
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign mode     = mode_q;
  assign pre_lim  = period_q[PRE_LSB +: PRE_W];
  assign cnt_lim  = period_q[0 +: CNT_W];
  assign rdata    = rdata_q;
  assign irq      = irq_q;
  assign wdog_rst = wd_q;

  // R4
  oneshot_stops_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !mode_q.wd && !mode_q.cont && !wr_mode) |=> !mode_q.en);
  // R9
  wd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && mode_q.wd) |=> wdog_rst);
  // R9
  wd_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q.wd && !flag_q) |=> !flag_q);
  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag_q);
  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && be[0] && wdata[0] && !expire) |=> !flag_q);
  // R11
  service_keeps_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_mode && be == 4'b1000 && !expire) |=> $stable(mode_q));
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
  import tmr_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        wdog_rst_o
);
  localparam int STAGES = 2;

  tmr_mode_t        mode;
  logic [PRE_W-1:0] pre_lim;
  logic [CNT_W-1:0] cnt_lim;
  logic             restart;
  logic [STAGES-1:0] tick;

  tmr_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .addr     (bus_addr),
    .be       (bus_be),
    .wdata    (bus_wdata),
    .expire   (tick[STAGES-1]),
    .mode     (mode),
    .pre_lim  (pre_lim),
    .cnt_lim  (cnt_lim),
    .restart  (restart),
    .rdata    (bus_rdata),
    .irq      (irq_o),
    .wdog_rst (wdog_rst_o)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_pre
      tmr_div #(.W(PRE_W)) u_div (
        .clk (clk), .rst (rst), .run (mode.en), .clr (restart),
        .step (1'b1), .lim (pre_lim), .tick (tick[s])
      );
    end else begin : g_cnt
      tmr_div #(.W(CNT_W)) u_div (
        .clk (clk), .rst (rst), .run (mode.en), .clr (restart),
        .step (tick[s-1]), .lim (cnt_lim), .tick (tick[s])
      );
    end
  end
endmodule

// File: tb/tmr_wdog_tb.sv
`timescale 1ns/1ps
module tmr_wdog_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, wdog_rst_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  tmr_wdog u_dut (
    .clk (clk), .rst (rst), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_be (bus_be), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .irq_o (irq_o), .wdog_rst_o (wdog_rst_o)
  );

  // {divider, limit, expected edges to expiry}
  localparam logic [47:0] VEC [5] = '{
    {16'd1, 16'd1, 16'd1},
    {16'd1, 16'd5, 16'd5},
    {16'd3, 16'd4, 16'd12},
    {16'd7, 16'd2, 16'd14},
    {16'd2, 16'd1, 16'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_be = b; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic any;
    wait_n(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 wdog", {31'b0, wdog_rst_o}, 0);
    rd(2'd0, v); chk("R1 mode", v, 0);
    rd(2'd1, v); chk("R1 period", v, 0);
    rd(2'd2, v); chk("R1 status", v, 0);

    // R2 R4 table of single-shot periods
    for (int i = 0; i < 5; i++) begin
      int n;
      n = int'(VEC[i][15:0]);
      wr(2'd1, 4'hF, VEC[i][47:16]);
      wr(2'd0, 4'b0010, 32'h0000_1100);
      wait_n(n - 1); chk("R2 before expiry", {31'b0, irq_o}, 0);
      wait_n(1);     chk("R2 at expiry", {31'b0, irq_o}, 1);
      rd(2'd0, v);   chk("R4 enable cleared", v, 32'h0000_0100);
      rd(2'd2, v);   chk("R4 flag set", v, 1);
      wr(2'd2, 4'b0001, 32'h1);
      chk("R6 cleared", {31'b0, irq_o}, 0);
      wait_n(n + 2); chk("R4 fires once", {31'b0, irq_o}, 0);
    end

    // R6 masked flag, write-zero, unmask, clear
    wr(2'd1, 4'hF, {16'd1, 16'd3});
    wr(2'd0, 4'b0010, 32'h0000_1000);
    wait_n(3); chk("R6 masked irq", {31'b0, irq_o}, 0);
    rd(2'd2, v); chk("R6 flag while masked", v, 1);
    wr(2'd2, 4'b0001, 32'h0);
    rd(2'd2, v); chk("R6 write zero keeps", v, 1);
    wr(2'd0, 4'b0010, 32'h0000_0100);
    chk("R6 unmask raises irq", {31'b0, irq_o}, 1);
    wr(2'd2, 4'b0001, 32'h1);
    chk("R6 clear drops irq", {31'b0, irq_o}, 0);

    // R5 continuous, then R7 disable
    wr(2'd1, 4'hF, {16'd2, 16'd3});
    wr(2'd0, 4'b0010, 32'h0000_1500);
    wait_n(5); chk("R5 first before", {31'b0, irq_o}, 0);
    wait_n(1); chk("R5 first", {31'b0, irq_o}, 1);
    wr(2'd2, 4'b0001, 32'h1);
    wait_n(4); chk("R5 second before", {31'b0, irq_o}, 0);
    wait_n(1); chk("R5 second", {31'b0, irq_o}, 1);
    wr(2'd0, 4'b0010, 32'h0000_0100);
    wr(2'd2, 4'b0001, 32'h1);
    wait_n(20); chk("R7 stopped", {31'b0, irq_o}, 0);

    // R7 stop mid-period
    wr(2'd1, 4'hF, {16'd1, 16'd10});
    wr(2'd0, 4'b0010, 32'h0000_1100);
    wait_n(4);
    wr(2'd0, 4'b0010, 32'h0000_0100);
    wait_n(20); chk("R7 mid stop irq", {31'b0, irq_o}, 0);
    rd(2'd2, v); chk("R7 mid stop flag", v, 0);

    // R8 reload on period write while running
    wr(2'd1, 4'hF, {16'd1, 16'd10});
    wr(2'd0, 4'b0010, 32'h0000_1100);
    wait_n(4);
    wr(2'd1, 4'hF, {16'd1, 16'd3});
    wait_n(2); chk("R8 before", {31'b0, irq_o}, 0);
    wait_n(1); chk("R8 at new expiry", {31'b0, irq_o}, 1);
    wr(2'd2, 4'b0001, 32'h1);

    // R3 divider zero = 65536
    wr(2'd1, 4'hF, {16'd0, 16'd1});
    wr(2'd0, 4'b0010, 32'h0000_1100);
    wait_n(65535); chk("R3 before", {31'b0, irq_o}, 0);
    wait_n(1);     chk("R3 at 65536", {31'b0, irq_o}, 1);
    wr(2'd2, 4'b0001, 32'h1);

    // R9 R10 watchdog
    wr(2'd1, 4'hF, {16'd1, 16'd8});
    wr(2'd0, 4'b0010, 32'h0000_9100);
    wait_n(2);
    wr(2'd0, 4'b1000, 32'h5A00_0000);   // wrong key at edge 3
    wait_n(4); chk("R10 wrong key no restart before", {31'b0, wdog_rst_o}, 0);
    wait_n(1); chk("R10 wrong key pulse on time", {31'b0, wdog_rst_o}, 1);
    chk("R9 no irq", {31'b0, irq_o}, 0);
    wait_n(1); chk("R9 one-cycle pulse", {31'b0, wdog_rst_o}, 0);
    rd(2'd2, v); chk("R9 no flag", v, 0);
    wait_n(1);
    wr(2'd0, 4'b1000, 32'hA500_0000);   // service at edge 12
    any = 1'b0;
    for (int k = 0; k < 7; k++) begin
      wait_n(1);
      any = any | wdog_rst_o;
    end
    chk("R10 service delays pulse", {31'b0, any}, 0);
    wait_n(1); chk("R10 pulse after service", {31'b0, wdog_rst_o}, 1);
    rd(2'd0, v); chk("R11 mode unchanged by key", v, 32'h0000_9100);
    wr(2'd0, 4'b0010, 32'h0);

    // R11 key in timer mode has no effect
    wr(2'd1, 4'hF, {16'd1, 16'd6});
    wr(2'd0, 4'b0010, 32'h0000_1100);
    wait_n(1);
    wr(2'd0, 4'b1000, 32'hA500_0000);
    wait_n(3); chk("R11 timer before", {31'b0, irq_o}, 0);
    wait_n(1); chk("R11 timer unaffected", {31'b0, irq_o}, 1);
    wr(2'd2, 4'b0001, 32'h1);

    // R12 read path and byte enables
    wr(2'd1, 4'hF, 32'h1234_5678);
    rd(2'd1, v); chk("R12 period readback", v, 32'h1234_5678);
    wr(2'd1, 4'b0100, 32'h00AB_0000);
    rd(2'd1, v); chk("R12 period byte write", v, 32'h12AB_5678);
    rd(2'd3, v); chk("R12 reserved reads zero", v, 0);
    wr(2'd0, 4'b0011, 32'h0000_FFFF);
    rd(2'd0, v); chk("R12 mode unused bits zero", v, 32'h0000_9500);
    wr(2'd0, 4'b0010, 32'h0);

    finish_run();
  end
endmodule